// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block decides which operating mode a CAN protocol peripheral is in, and it drives the status flags and transmit-pin behaviour that belong to each mode. Software controls it with three control bits, written together through one strobe: a module-off bit, a halt request and a freeze permit. Out of reset the peripheral is switched off. Clearing the off bit moves it straight into freeze mode. In freeze mode the protocol engine is held idle and detached from the bus, and configuration may be written. Releasing the halt request, or the freeze permit, starts a bus-idle search. Once the receive line has shown a run of recessive bits, the peripheral goes into normal operation.

The block also guards configuration storage. The clock-source selection is held inside the block and may change only while the peripheral is switched off. Per-register configuration write strobes pass through only in freeze mode. A write attempted in the wrong mode is dropped, and it sets a sticky error flag.

Top module: `can_mode_ctrl`

## Requirements
- R1: `clksel_o` takes the value of `clksel_i` on a `clksel_we_i` strobe only while `mode_o` is off (code 0). In any other mode the strobe leaves `clksel_o` unchanged.
- R2: A control write with the off bit clear, made while the peripheral is off, gives freeze mode (code 1) on the next cycle, with `halt_o` and `frz_o` both set, whatever halt and freeze values were written.
- R3: Throughout freeze mode, `halt_o`, `frz_o`, `frz_ack_o` and `not_rdy_o` all read 1.
- R4: Outside normal mode, `engine_en_o` is 0 and `tx_o` is 1 (recessive), whatever `eng_tx_i` is.
- R5: A control write in freeze mode that clears the halt bit or the freeze bit gives the idle-search mode (code 2) on the next cycle. Normal mode (code 3) follows only after IDLE_BITS (default 11) consecutive `bit_tick_i` samples with `rx_i` = 1. A sample with `rx_i` = 0 restarts the count. `not_rdy_o` stays 1 until normal mode is reached.
- R6: Each bit of `cfg_we_o` follows the matching bit of `cfg_we_i` in freeze mode, and is 0 in every other mode.
- R7: A `cfg_we_i` strobe outside freeze mode, or a `clksel_we_i` strobe outside off mode, sets `wr_err_o` on the next cycle. The flag then stays set until reset.
- R8: A control write with the off bit set gives off mode on the next cycle from any mode, with `lpm_ack_o` = 1.
- R9: A control write with both halt and freeze set, made in idle-search or normal mode, gives freeze mode on the next cycle.
- R10: After reset, `mode_o` = 0, `lpm_ack_o` = 1, `not_rdy_o` = 1, `halt_o` = `frz_o` = 1, `tx_o` = 1, `clksel_o` = 0 and `wr_err_o` = 0. The mode codes are: off 0, freeze 1, idle-search 2, normal 3.
- R11: In normal mode, `engine_en_o` = 1 and `tx_o` equals `eng_tx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we_i | input | 1 | Control-bit write strobe |
| ctl_dis_i | input | 1 | Written value of the module-off bit |
| ctl_halt_i | input | 1 | Written value of the halt request |
| ctl_frz_i | input | 1 | Written value of the freeze permit |
| clksel_we_i | input | 1 | Clock-source select write strobe |
| clksel_i | input | CLKSEL_W | Clock-source select write data |
| cfg_we_i | input | NUM_CFG | Per-register configuration write strobes |
| bit_tick_i | input | 1 | Bit sample strobe from the bit timing logic |
| rx_i | input | 1 | Receive line value |
| eng_tx_i | input | 1 | Transmit value from the protocol engine |
| mode_o | output | 2 | Current mode code |
| halt_o | output | 1 | Halt request readback |
| frz_o | output | 1 | Freeze permit readback |
| frz_ack_o | output | 1 | Freeze acknowledge |
| not_rdy_o | output | 1 | Not ready (not in normal mode) |
| lpm_ack_o | output | 1 | Low-power (off) acknowledge |
| engine_en_o | output | 1 | Protocol engine enable |
| tx_o | output | 1 | Transmit pin |
| clksel_o | output | CLKSEL_W | Held clock-source selection |
| cfg_we_o | output | NUM_CFG | Gated configuration write strobes |
| wr_err_o | output | 1 | Sticky misplaced-write error |

## Verification
Mode changes, the held clock selection and the error flag are all registered, so each one is due one clock edge after its strobe. The bench drives each strobe on a falling edge, holds it through one rising edge, and checks the outputs at the following falling edge. The gated strobes, the transmit pin, the engine enable and the status flags decode the current mode combinationally, so they are checked a short delay after the input is applied, within the same cycle. For the idle search, the checks are placed after the tenth and after the eleventh recessive sample that follows a dominant one, so that a count which runs one sample long or one short is caught.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
   typedef enum logic [1:0] {
      MODE_OFF  = 2'd0,
      MODE_FRZ  = 2'd1,
      MODE_SYNC = 2'd2,
      MODE_RUN  = 2'd3
   } mode_e;
endpackage

// File: rtl/can_idle_det.sv
module can_idle_det #(
   parameter int IDLE_BITS = 11,
   parameter bit WAIT_IDLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic bit_tick,
   input  logic rx,
   output logic done
);
   localparam int CW = $clog2(IDLE_BITS + 1);

   generate
      if (WAIT_IDLE) begin : g_count
         logic [CW-1:0] run_q;
         logic          last_bit;
         assign last_bit = (run_q == CW'(IDLE_BITS - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               run_q <= '0;
            else if (!active)
               run_q <= '0;
            else if (bit_tick) begin
               if (!rx)
                  run_q <= '0;
               else if (!last_bit)
                  run_q <= run_q + 1'b1;
            end
         end
         assign done = active && bit_tick && rx && last_bit;
      end else begin : g_direct
         logic unused_inputs;
         assign unused_inputs = ^{clk, rst_n, bit_tick, rx};
         assign done = active;
      end
   endgenerate
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
   import can_mode_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ctl_we,
   input  logic  ctl_dis,
   input  logic  ctl_halt,
   input  logic  ctl_frz,
   input  logic  idle_done,
   output mode_e mode,
   output logic  halt,
   output logic  frz
);
   mode_e mode_q, mode_d;
   logic  halt_q, halt_d, frz_q, frz_d;

   always_comb begin
      mode_d = mode_q;
      halt_d = halt_q;
      frz_d  = frz_q;
      if (ctl_we) begin
         halt_d = ctl_halt;
         frz_d  = ctl_frz;
      end
      if (ctl_we && ctl_dis) begin
         mode_d = MODE_OFF;
      end else begin
         unique case (mode_q)
            MODE_OFF: begin
               if (ctl_we) begin
                  mode_d = MODE_FRZ;
                  halt_d = 1'b1;
                  frz_d  = 1'b1;
               end
            end
            MODE_FRZ: begin
               if (ctl_we && !(ctl_halt && ctl_frz))
                  mode_d = MODE_SYNC;
            end
            MODE_SYNC: begin
               if (ctl_we && ctl_halt && ctl_frz)
                  mode_d = MODE_FRZ;
               else if (idle_done)
                  mode_d = MODE_RUN;
            end
            MODE_RUN: begin
               if (ctl_we && ctl_halt && ctl_frz)
                  mode_d = MODE_FRZ;
            end
            default: mode_d = MODE_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_OFF;
         halt_q <= 1'b1;
         frz_q  <= 1'b1;
      end else begin
         mode_q <= mode_d;
         halt_q <= halt_d;
         frz_q  <= frz_d;
      end
   end

   assign mode = mode_q;
   assign halt = halt_q;
   assign frz  = frz_q;
endmodule

// File: rtl/can_cfg_gate.sv
module can_cfg_gate
   import can_mode_pkg::*;
#(
   parameter int NUM_CFG  = 4,
   parameter int CLKSEL_W = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  mode_e               mode,
   input  logic                clksel_we,
   input  logic [CLKSEL_W-1:0] clksel,
   input  logic [NUM_CFG-1:0]  cfg_we,
   output logic [CLKSEL_W-1:0] clksel_q,
   output logic [NUM_CFG-1:0]  cfg_we_g,
   output logic                wr_err
);
   logic off_mode, frz_mode, bad_wr;

   assign off_mode = (mode == MODE_OFF);
   assign frz_mode = (mode == MODE_FRZ);
   assign bad_wr   = (clksel_we && !off_mode) || (|cfg_we && !frz_mode);

   generate
      for (genvar i = 0; i < NUM_CFG; i++) begin : g_gate
         assign cfg_we_g[i] = cfg_we[i] & frz_mode;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clksel_q <= '0;
         wr_err   <= 1'b0;
      end else begin
         if (clksel_we && off_mode)
            clksel_q <= clksel;
         if (bad_wr)
            wr_err <= 1'b1;
      end
   end
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
   import can_mode_pkg::*;
#(
   parameter int NUM_CFG   = 4,
   parameter int CLKSEL_W  = 1,
   parameter int IDLE_BITS = 11,
   parameter bit WAIT_IDLE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ctl_we_i,
   input  logic                ctl_dis_i,
   input  logic                ctl_halt_i,
   input  logic                ctl_frz_i,
   input  logic                clksel_we_i,
   input  logic [CLKSEL_W-1:0] clksel_i,
   input  logic [NUM_CFG-1:0]  cfg_we_i,
   input  logic                bit_tick_i,
   input  logic                rx_i,
   input  logic                eng_tx_i,
   output logic [1:0]          mode_o,
   output logic                halt_o,
   output logic                frz_o,
   output logic                frz_ack_o,
   output logic                not_rdy_o,
   output logic                lpm_ack_o,
   output logic                engine_en_o,
   output logic                tx_o,
   output logic [CLKSEL_W-1:0] clksel_o,
   output logic [NUM_CFG-1:0]  cfg_we_o,
   output logic                wr_err_o
);
   if (NUM_CFG < 1) begin : g_bad_cfg
      $error("NUM_CFG must be at least 1");
   end
   if (CLKSEL_W < 1) begin : g_bad_clk
      $error("CLKSEL_W must be at least 1");
   end
   if (IDLE_BITS < 1) begin : g_bad_idle
      $error("IDLE_BITS must be at least 1");
   end

   mode_e mode;
   logic  idle_done;

   can_mode_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (ctl_we_i),
      .ctl_dis   (ctl_dis_i),
      .ctl_halt  (ctl_halt_i),
      .ctl_frz   (ctl_frz_i),
      .idle_done (idle_done),
      .mode      (mode),
      .halt      (halt_o),
      .frz       (frz_o)
   );

   can_idle_det #(
      .IDLE_BITS (IDLE_BITS),
      .WAIT_IDLE (WAIT_IDLE)
   ) u_idle (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (mode == MODE_SYNC),
      .bit_tick (bit_tick_i),
      .rx       (rx_i),
      .done     (idle_done)
   );

   can_cfg_gate #(
      .NUM_CFG  (NUM_CFG),
      .CLKSEL_W (CLKSEL_W)
   ) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .clksel_we (clksel_we_i),
      .clksel    (clksel_i),
      .cfg_we    (cfg_we_i),
      .clksel_q  (clksel_o),
      .cfg_we_g  (cfg_we_o),
      .wr_err    (wr_err_o)
   );

   assign mode_o      = mode;
   assign frz_ack_o   = (mode == MODE_FRZ);
   assign not_rdy_o   = (mode != MODE_RUN);
   assign lpm_ack_o   = (mode == MODE_OFF);
   assign engine_en_o = (mode == MODE_RUN);
   assign tx_o        = (mode == MODE_RUN) ? eng_tx_i : 1'b1;
endmodule

// File: rtl/can_mode_chk.sv
module can_mode_chk #(
   parameter int NUM_CFG  = 4,
   parameter int CLKSEL_W = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ctl_we_i,
   input logic                ctl_dis_i,
   input logic                ctl_halt_i,
   input logic                ctl_frz_i,
   input logic [1:0]          mode_o,
   input logic                halt_o,
   input logic                frz_o,
   input logic                frz_ack_o,
   input logic                not_rdy_o,
   input logic                lpm_ack_o,
   input logic                engine_en_o,
   input logic                tx_o,
   input logic [CLKSEL_W-1:0] clksel_o,
   input logic [NUM_CFG-1:0]  cfg_we_o,
   input logic                wr_err_o
);
   AST_CLKSEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != 2'd0) |=> $stable(clksel_o)); // R1
   AST_ENABLE_TO_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd0 && ctl_we_i && !ctl_dis_i) |=> (mode_o == 2'd1 && halt_o && frz_o)); // R2
   AST_FREEZE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'd1) |-> (halt_o && frz_o && frz_ack_o && not_rdy_o)); // R3
   AST_IDLE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != 2'd3) |-> (tx_o && !engine_en_o)); // R4
   AST_RUN_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_o == 2'd3) |-> ($past(mode_o) == 2'd2)); // R5
   AST_CFG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (|cfg_we_o) |-> (mode_o == 2'd1)); // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err_o |=> wr_err_o); // R7
   AST_OFF_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we_i && ctl_dis_i) |=> (mode_o == 2'd0 && lpm_ack_o)); // R8
   AST_REFREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o[1] && ctl_we_i && !ctl_dis_i && ctl_halt_i && ctl_frz_i) |=> (mode_o == 2'd1)); // R9
endmodule

bind can_mode_ctrl can_mode_chk #(
   .NUM_CFG  (NUM_CFG),
   .CLKSEL_W (CLKSEL_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl_we_i    (ctl_we_i),
   .ctl_dis_i   (ctl_dis_i),
   .ctl_halt_i  (ctl_halt_i),
   .ctl_frz_i   (ctl_frz_i),
   .mode_o      (mode_o),
   .halt_o      (halt_o),
   .frz_o       (frz_o),
   .frz_ack_o   (frz_ack_o),
   .not_rdy_o   (not_rdy_o),
   .lpm_ack_o   (lpm_ack_o),
   .engine_en_o (engine_en_o),
   .tx_o        (tx_o),
   .clksel_o    (clksel_o),
   .cfg_we_o    (cfg_we_o),
   .wr_err_o    (wr_err_o)
);

// File: tb/sim_can_mode_ctrl.sv
`timescale 1ns/1ps
module sim_can_mode_ctrl;
   localparam int NCFG = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ctl_we = 0, ctl_dis = 0, ctl_halt = 0, ctl_frz = 0;
   logic            clksel_we = 0;
   logic [0:0]      clksel = 0;
   logic [NCFG-1:0] cfg_we = '0;
   logic            bit_tick = 0, rx = 1, eng_tx = 1;
   logic [1:0]      mode;
   logic            halt, frz, frz_ack, not_rdy, lpm_ack, eng_en, tx, wr_err;
   logic [0:0]      clksel_q;
   logic [NCFG-1:0] cfg_we_g;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   can_mode_ctrl #(.NUM_CFG(NCFG), .CLKSEL_W(1), .IDLE_BITS(11), .WAIT_IDLE(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .ctl_we_i(ctl_we), .ctl_dis_i(ctl_dis),
      .ctl_halt_i(ctl_halt), .ctl_frz_i(ctl_frz), .clksel_we_i(clksel_we),
      .clksel_i(clksel), .cfg_we_i(cfg_we), .bit_tick_i(bit_tick), .rx_i(rx),
      .eng_tx_i(eng_tx), .mode_o(mode), .halt_o(halt), .frz_o(frz),
      .frz_ack_o(frz_ack), .not_rdy_o(not_rdy), .lpm_ack_o(lpm_ack),
      .engine_en_o(eng_en), .tx_o(tx), .clksel_o(clksel_q), .cfg_we_o(cfg_we_g),
      .wr_err_o(wr_err));

   // entry: {dis, halt, frz written, expected mode[1:0], halt, frz, lpm_ack}
   localparam logic [7:0] VEC [8] = '{
      8'b0_0_0_01_1_1_0,
      8'b0_0_1_10_0_1_0,
      8'b0_1_1_01_1_1_0,
      8'b1_1_1_00_1_1_1,
      8'b0_1_1_01_1_1_0,
      8'b0_1_0_10_1_0_0,
      8'b1_0_0_00_0_0_1,
      8'b0_0_0_01_1_1_0
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic ctl_write(input logic d, input logic h, input logic f);
      @(negedge clk);
      ctl_we = 1; ctl_dis = d; ctl_halt = h; ctl_frz = f;
      @(negedge clk);
      ctl_we = 0;
   endtask

   task automatic sample(input logic r);
      @(negedge clk);
      bit_tick = 1; rx = r;
      @(negedge clk);
      bit_tick = 0; rx = 1;
   endtask

   task automatic do_reset;
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic to_run;
      ctl_write(0, 0, 0);
      ctl_write(0, 0, 1);
      for (int k = 0; k < 11; k++) sample(1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      // R10 reset state
      check("R10 mode", mode, 0);
      check("R10 lpm_ack", lpm_ack, 1);
      check("R10 not_rdy", not_rdy, 1);
      check("R10 halt/frz", {halt, frz}, 2'b11);
      check("R10 tx", tx, 1);
      check("R10 clksel", clksel_q, 0);
      check("R10 wr_err", wr_err, 0);

      // table walk: R2 R3 R5 R8 R9
      for (int i = 0; i < 8; i++) begin
         ctl_write(VEC[i][7], VEC[i][6], VEC[i][5]);
         check($sformatf("R2_R5_R8_R9 vec%0d mode", i), mode, VEC[i][4:3]);
         check($sformatf("R3 vec%0d halt/frz", i), {halt, frz}, VEC[i][2:1]);
         check($sformatf("R8 vec%0d lpm_ack", i), lpm_ack, VEC[i][0]);
         if (VEC[i][4:3] == 2'd1)
            check($sformatf("R3 vec%0d ack/nrdy", i), {frz_ack, not_rdy}, 2'b11);
      end

      // R1: clock select in off mode, then blocked in freeze
      do_reset();
      @(negedge clk); clksel_we = 1; clksel = 1;
      @(negedge clk); clksel_we = 0; clksel = 0;
      check("R1 clksel taken when off", clksel_q, 1);
      check("R7 no error when off", wr_err, 0);
      ctl_write(0, 0, 0);
      @(negedge clk); clksel_we = 1; clksel = 0;
      @(negedge clk); clksel_we = 0;
      check("R1 clksel held in freeze", clksel_q, 1);
      check("R7 error after clksel in freeze", wr_err, 1);

      // R6 / R4 in freeze
      @(negedge clk); cfg_we = 4'b1010; eng_tx = 0;
      #1;
      check("R6 strobes pass in freeze", cfg_we_g, 4'b1010);
      check("R4 tx recessive in freeze", tx, 1);
      check("R4 engine off in freeze", eng_en, 0);
      @(negedge clk); cfg_we = '0; eng_tx = 1;

      // R5 idle search with restart
      do_reset();
      ctl_write(0, 0, 0);
      ctl_write(0, 0, 1);
      check("R5 idle search mode", mode, 2);
      for (int k = 0; k < 5; k++) sample(1);
      sample(0);
      check("R5 still searching after dominant", mode, 2);
      for (int k = 0; k < 10; k++) sample(1);
      check("R5 ten recessive not enough", {mode, not_rdy}, {2'd2, 1'b1});
      check("R4 tx recessive while searching", tx, 1);
      sample(1);
      check("R5 normal after eleven", {mode, not_rdy}, {2'd3, 1'b0});

      // R11 normal pin behaviour
      @(negedge clk); eng_tx = 0; #1;
      check("R11 tx follows engine", tx, 0);
      check("R11 engine enabled", eng_en, 1);
      @(negedge clk); eng_tx = 1; #1;
      check("R11 tx follows engine high", tx, 1);

      // R6 / R7 in normal
      check("R7 no error yet", wr_err, 0);
      @(negedge clk); cfg_we = 4'b0001; #1;
      check("R6 strobes blocked in normal", cfg_we_g, 4'b0000);
      @(negedge clk); cfg_we = '0;
      check("R7 error after cfg write in normal", wr_err, 1);
      repeat (3) @(negedge clk);
      check("R7 error sticky", wr_err, 1);

      // R9 refreeze from normal, R4 in freeze
      ctl_write(0, 1, 1);
      check("R9 normal to freeze", mode, 1);
      @(negedge clk); eng_tx = 0; #1;
      check("R4 tx recessive after refreeze", tx, 1);
      @(negedge clk); eng_tx = 1;

      // R8 off from normal
      do_reset();
      to_run();
      check("R5 reached normal", mode, 3);
      ctl_write(1, 0, 1);
      check("R8 off from normal", {mode, lpm_ack}, {2'd0, 1'b1});

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule